// File: doc/BRIEF.md
# OLED Panel Power and Initialization Sequencer

This block brings a small monochrome passive-matrix OLED panel up from cold and takes it back down without stressing it. It owns three rail controls: the logic-supply enable, the panel high-voltage enable (an external panel supply or the driver's internal charge-pump input, depending on board build) and the panel's active-low reset. Between rail actions it emits command bytes one at a time through a request/acknowledge handshake to a separate two-wire bus master. It also asks a separate engine to clear the frame memory, and inserts timed waits that are derived from the clock frequency.

A fixed step table holds four programs: power-up, power-down, sleep entry and sleep exit. Each table entry is one of a command byte, a mode-dependent charge-pump argument, a rail action, a short or long wait, a clear request, or an end marker that names the steady state to settle in. The `pump_mode` input is sampled when power-up is accepted and selects the pump variant for every later program until the next power-up. A refused byte aborts every program to the off state with all rails dropped and a fault flag raised.

The controller states are `S_OFF`, `S_ON` and `S_SLEEP` (steady), and `S_FETCH`, `S_SEND`, `S_WAIT` and `S_CLEAR` (sequencing). The transitions are as follows:
- OFF→FETCH on a power-up request.
- ON→FETCH on a power-down or sleep request.
- SLEEP→FETCH on a power-down or wake request.
- FETCH loops on rail actions and on skipped pump-only bytes. It goes to SEND on a byte, to WAIT on a wait entry and to CLEAR on a clear entry. At an end entry it goes to the state that the entry names.
- SEND→FETCH on acknowledge and SEND→OFF on refusal.
- WAIT→FETCH when the timer expires.
- CLEAR→FETCH when the clear is done.

Top module: `oled_pwr_seq`

## Requirements
- R1: After reset, `logic_en`, `panel_en` and `panel_rst_n` are 0. `status` is 0 (off), and `busy`, `cmd_req`, `clr_req` and `fault` are 0.
- R2: Power-up first sets `logic_en` while `panel_rst_n` stays low. `panel_rst_n` rises at least SHORT cycles later, where SHORT = ceil(CLK_HZ·RESET_US/10^6) with a minimum of 1. The first command byte follows at least SHORT cycles after the reset release.
- R3: The power-up bytes go out in exactly this order: AE, D5 80, A8 0F, D3 00, 40, 8D p, A1, C8, DA 02, DB 20, D9 F1, 81 AF, A4, A6 (22 bytes), then AF once the panel rail is up. Here p is 0x14 if `pump_mode` was 1 when power-up was accepted, and 0x10 otherwise.
- R4: `clr_req` rises only after the 22nd power-up byte is acknowledged and while `panel_en` is still 0. `panel_en` rises only after `clr_done`.
- R5: The final AF is sent at least LONG cycles after `panel_en` rises, where LONG = (CLK_HZ/1000)·RAIL_MS. The block then reports on with all three rails high.
- R6: Power-down sends AE, and then 8D 10 in pump mode. It then clears `panel_en`, waits at least LONG cycles, and clears `logic_en` and `panel_rst_n` together, ending in off. `logic_en` never falls while `panel_en` is high, except on an abort.
- R7: Sleep entry sends AE, and then 8D 10 in pump mode. It then clears `panel_en`, keeps `logic_en` and `panel_rst_n` high, and reports sleep.
- R8: Sleep exit sends 8D 14 in pump mode only. It then sets `panel_en`, waits at least LONG cycles, sends AF and reports on.
- R9: A request is accepted only in its matching steady state: power-up in off, sleep in on, wake in sleep, and power-down in on or sleep. Any other request, including every request made while a program runs, has no effect on bytes, rails or state.
- R10: A refused byte (`cmd_nack`) drops all three rails in one cycle, sets `fault` and returns to off. `fault` stays set until the next accepted power-up clears it.
- R11: `cmd_req` holds high with a stable `cmd_byte` until `cmd_ack` or `cmd_nack`, and is low in the following cycle.
- R12: The `status` codes are 0 off, 1 sequencing, 2 on and 3 sleep. `busy` is high exactly when `status` is 1.
- R13: `panel_en` is never high unless `logic_en` and `panel_rst_n` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous-release reset |
| pump_mode | input | 1 | 1 selects the internal charge pump, 0 an external panel supply; sampled at power-up accept |
| up_req | input | 1 | Power-up request |
| down_req | input | 1 | Power-down request |
| sleep_req | input | 1 | Sleep entry request |
| wake_req | input | 1 | Sleep exit request |
| cmd_req | output | 1 | Byte-write request to the bus master |
| cmd_byte | output | 8 | Command byte to write |
| cmd_ack | input | 1 | Byte accepted |
| cmd_nack | input | 1 | Byte refused |
| clr_req | output | 1 | Frame-memory clear request, held until done |
| clr_done | input | 1 | Clear finished |
| logic_en | output | 1 | Logic-supply enable |
| panel_en | output | 1 | Panel high-voltage enable |
| panel_rst_n | output | 1 | Panel reset, active low |
| busy | output | 1 | A program is running |
| status | output | 2 | 0 off, 1 sequencing, 2 on, 3 sleep |
| fault | output | 1 | Latched abort flag |

## Verification
Two things can meet in one cycle: a user request and a running program. The bench pulses sleep and power-down together while the power-up command list is still being sent, and power-up with wake while the block is on. It judges the result by a byte log that must match the expected list exactly, and by the final steady state. The other collision is a refusal landing on the handshake. Refusing the sixth power-up byte must drop all rails at once, latch the fault and leave exactly six bytes in the log, and a fresh power-up must then clear the fault and complete normally.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

    localparam int STEP_W = 6;

    typedef enum logic [2:0] {
        K_CMD     = 3'd0,
        K_PUMPARG = 3'd1,
        K_RAIL    = 3'd2,
        K_WAIT    = 3'd3,
        K_CLEAR   = 3'd4,
        K_END     = 3'd5
    } step_kind_t;

    typedef struct packed {
        step_kind_t  kind;
        logic        pump_only;
        logic [7:0]  arg;
    } step_t;

    typedef enum logic [1:0] {
        STAT_OFF   = 2'd0,
        STAT_BUSY  = 2'd1,
        STAT_ON    = 2'd2,
        STAT_SLEEP = 2'd3
    } status_t;

    // rail action codes carried in arg of a K_RAIL entry
    localparam logic [7:0] RAIL_LOGIC_ON  = 8'd0;
    localparam logic [7:0] RAIL_RST_REL   = 8'd1;
    localparam logic [7:0] RAIL_PANEL_ON  = 8'd2;
    localparam logic [7:0] RAIL_PANEL_OFF = 8'd3;
    localparam logic [7:0] RAIL_LOGIC_OFF = 8'd4;

    localparam logic [7:0] WAIT_SHORT = 8'd0;
    localparam logic [7:0] WAIT_LONG  = 8'd1;

    localparam logic [7:0] PUMP_OFF_ARG = 8'h10;
    localparam logic [7:0] PUMP_ON_ARG  = 8'h14;

    // program entry points in the step table
    localparam logic [STEP_W-1:0] PROG_UP    = 6'd0;
    localparam logic [STEP_W-1:0] PROG_DOWN  = 6'd31;
    localparam logic [STEP_W-1:0] PROG_SLEEP = 6'd38;
    localparam logic [STEP_W-1:0] PROG_WAKE  = 6'd43;

    function automatic step_t mk_step(step_kind_t k, logic p, logic [7:0] a);
        step_t s;
        s.kind      = k;
        s.pump_only = p;
        s.arg       = a;
        return s;
    endfunction

endpackage

// File: rtl/oled_step_rom.sv
module oled_step_rom
    import oled_seq_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output step_t             entry
);

    function automatic step_t cmd(logic [7:0] b);
        return mk_step(K_CMD, 1'b0, b);
    endfunction

    function automatic step_t pcmd(logic [7:0] b);
        return mk_step(K_CMD, 1'b1, b);
    endfunction

    function automatic step_t rail(logic [7:0] a);
        return mk_step(K_RAIL, 1'b0, a);
    endfunction

    function automatic step_t fin(status_t s);
        return mk_step(K_END, 1'b0, {6'd0, 2'(s)});
    endfunction

    always_comb begin
        case (idx)
            // power-up
            6'd0:  entry = rail(RAIL_LOGIC_ON);
            6'd1:  entry = mk_step(K_WAIT, 1'b0, WAIT_SHORT);
            6'd2:  entry = rail(RAIL_RST_REL);
            6'd3:  entry = mk_step(K_WAIT, 1'b0, WAIT_SHORT);
            6'd4:  entry = cmd(8'hAE);
            6'd5:  entry = cmd(8'hD5);
            6'd6:  entry = cmd(8'h80);
            6'd7:  entry = cmd(8'hA8);
            6'd8:  entry = cmd(8'h0F);
            6'd9:  entry = cmd(8'hD3);
            6'd10: entry = cmd(8'h00);
            6'd11: entry = cmd(8'h40);
            6'd12: entry = cmd(8'h8D);
            6'd13: entry = mk_step(K_PUMPARG, 1'b0, 8'h00);
            6'd14: entry = cmd(8'hA1);
            6'd15: entry = cmd(8'hC8);
            6'd16: entry = cmd(8'hDA);
            6'd17: entry = cmd(8'h02);
            6'd18: entry = cmd(8'hDB);
            6'd19: entry = cmd(8'h20);
            6'd20: entry = cmd(8'hD9);
            6'd21: entry = cmd(8'hF1);
            6'd22: entry = cmd(8'h81);
            6'd23: entry = cmd(8'hAF);
            6'd24: entry = cmd(8'hA4);
            6'd25: entry = cmd(8'hA6);
            6'd26: entry = mk_step(K_CLEAR, 1'b0, 8'h00);
            6'd27: entry = rail(RAIL_PANEL_ON);
            6'd28: entry = mk_step(K_WAIT, 1'b0, WAIT_LONG);
            6'd29: entry = cmd(8'hAF);
            6'd30: entry = fin(STAT_ON);
            // power-down
            6'd31: entry = cmd(8'hAE);
            6'd32: entry = pcmd(8'h8D);
            6'd33: entry = pcmd(PUMP_OFF_ARG);
            6'd34: entry = rail(RAIL_PANEL_OFF);
            6'd35: entry = mk_step(K_WAIT, 1'b0, WAIT_LONG);
            6'd36: entry = rail(RAIL_LOGIC_OFF);
            6'd37: entry = fin(STAT_OFF);
            // sleep entry
            6'd38: entry = cmd(8'hAE);
            6'd39: entry = pcmd(8'h8D);
            6'd40: entry = pcmd(PUMP_OFF_ARG);
            6'd41: entry = rail(RAIL_PANEL_OFF);
            6'd42: entry = fin(STAT_SLEEP);
            // sleep exit
            6'd43: entry = pcmd(8'h8D);
            6'd44: entry = pcmd(PUMP_ON_ARG);
            6'd45: entry = rail(RAIL_PANEL_ON);
            6'd46: entry = mk_step(K_WAIT, 1'b0, WAIT_LONG);
            6'd47: entry = cmd(8'hAF);
            6'd48: entry = fin(STAT_ON);
            default: entry = fin(STAT_OFF);
        endcase
    end

endmodule

// File: rtl/oled_delay_timer.sv
module oled_delay_timer #(
    parameter int unsigned SHORT_CYC = 3,
    parameter int unsigned LONG_CYC  = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_long,
    output logic done
);

    localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int          TW      = $clog2(MAX_CYC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= sel_long ? TW'(LONG_CYC) : TW'(SHORT_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0) && !load;

    // the sequencer must never restart a wait that is still running (R5)
    assert_timer_idle_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> cnt == '0);

endmodule

// File: rtl/oled_byte_port.sv
module oled_byte_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_in,
    input  logic       wr_ack,
    input  logic       wr_nack,
    output logic       wr_req,
    output logic [7:0] wr_data,
    output logic       done,
    output logic       nacked
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_req  <= 1'b0;
            wr_data <= 8'h00;
        end else if (start) begin
            wr_req  <= 1'b1;
            wr_data <= byte_in;
        end else if (wr_req && (wr_ack || wr_nack)) begin
            wr_req  <= 1'b0;
        end
    end

    assign done   = wr_req && wr_ack && !wr_nack;
    assign nacked = wr_req && wr_nack;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack && !wr_nack |=> wr_req && $stable(wr_data));

    assert_req_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && (wr_ack || wr_nack) |=> !wr_req);

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !wr_req);

endmodule

// File: rtl/oled_pwr_seq.sv
module oled_pwr_seq
    import oled_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned RESET_US = 3,
    parameter int unsigned RAIL_MS  = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pump_mode,
    input  logic       up_req,
    input  logic       down_req,
    input  logic       sleep_req,
    input  logic       wake_req,
    output logic       cmd_req,
    output logic [7:0] cmd_byte,
    input  logic       cmd_ack,
    input  logic       cmd_nack,
    output logic       clr_req,
    input  logic       clr_done,
    output logic       logic_en,
    output logic       panel_en,
    output logic       panel_rst_n,
    output logic       busy,
    output logic [1:0] status,
    output logic       fault
);

    localparam int unsigned SHORT_RAW = (CLK_HZ * RESET_US + 999_999) / 1_000_000;
    localparam int unsigned SHORT_CYC = (SHORT_RAW < 1) ? 1 : SHORT_RAW;
    localparam int unsigned LONG_RAW  = (CLK_HZ / 1000) * RAIL_MS;
    localparam int unsigned LONG_CYC  = (LONG_RAW < 1) ? 1 : LONG_RAW;

    typedef enum logic [2:0] {
        S_OFF, S_FETCH, S_SEND, S_WAIT, S_CLEAR, S_ON, S_SLEEP
    } state_t;

    state_t            state, state_nx;
    logic [STEP_W-1:0] step;
    step_t             entry;
    logic              mode_q;
    logic              logic_q, panel_q, prst_q, fault_q, clr_q;
    logic              acc_up, acc_dn, acc_sl, acc_wk;
    logic              is_byte, skip, byte_start, tmr_load, tmr_done;
    logic              bp_done, bp_nack;
    logic [7:0]        byte_val;
    status_t           stat;

    oled_step_rom u_rom (
        .idx   (step),
        .entry (entry)
    );

    oled_delay_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .sel_long (entry.arg[0]),
        .done     (tmr_done)
    );

    oled_byte_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (byte_start),
        .byte_in (byte_val),
        .wr_ack  (cmd_ack),
        .wr_nack (cmd_nack),
        .wr_req  (cmd_req),
        .wr_data (cmd_byte),
        .done    (bp_done),
        .nacked  (bp_nack)
    );

    // request acceptance and step decode
    always_comb begin
        acc_up     = (state == S_OFF) && up_req;
        acc_dn     = ((state == S_ON) || (state == S_SLEEP)) && down_req;
        acc_sl     = (state == S_ON) && sleep_req && !down_req;
        acc_wk     = (state == S_SLEEP) && wake_req && !down_req;
        is_byte    = (entry.kind == K_CMD) || (entry.kind == K_PUMPARG);
        skip       = is_byte && entry.pump_only && !mode_q;
        byte_start = (state == S_FETCH) && is_byte && !skip;
        tmr_load   = (state == S_FETCH) && (entry.kind == K_WAIT);
        byte_val   = (entry.kind == K_PUMPARG) ? (mode_q ? PUMP_ON_ARG : PUMP_OFF_ARG)
                                               : entry.arg;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:   if (acc_up) state_nx = S_FETCH;
            S_ON:    if (acc_dn || acc_sl) state_nx = S_FETCH;
            S_SLEEP: if (acc_dn || acc_wk) state_nx = S_FETCH;
            S_FETCH: begin
                unique case (entry.kind)
                    K_CMD, K_PUMPARG: state_nx = skip ? S_FETCH : S_SEND;
                    K_RAIL:           state_nx = S_FETCH;
                    K_WAIT:           state_nx = S_WAIT;
                    K_CLEAR:          state_nx = S_CLEAR;
                    K_END: begin
                        case (entry.arg[1:0])
                            STAT_ON:    state_nx = S_ON;
                            STAT_SLEEP: state_nx = S_SLEEP;
                            default:    state_nx = S_OFF;
                        endcase
                    end
                    default:          state_nx = S_OFF;
                endcase
            end
            S_SEND: begin
                if (bp_nack)      state_nx = S_OFF;
                else if (bp_done) state_nx = S_FETCH;
            end
            S_WAIT:  if (tmr_done) state_nx = S_FETCH;
            S_CLEAR: if (clr_done) state_nx = S_FETCH;
            default: state_nx = S_OFF;
        endcase
    end

    // step counter, rails, mode latch, clear request, fault
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step    <= PROG_UP;
            mode_q  <= 1'b0;
            logic_q <= 1'b0;
            panel_q <= 1'b0;
            prst_q  <= 1'b0;
            fault_q <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            if (acc_up) begin
                step    <= PROG_UP;
                mode_q  <= pump_mode;
                fault_q <= 1'b0;
            end else if (acc_dn) begin
                step <= PROG_DOWN;
            end else if (acc_sl) begin
                step <= PROG_SLEEP;
            end else if (acc_wk) begin
                step <= PROG_WAKE;
            end

            if (state == S_FETCH) begin
                if (entry.kind == K_RAIL) begin
                    step <= step + 1'b1;
                    case (entry.arg)
                        RAIL_LOGIC_ON:  logic_q <= 1'b1;
                        RAIL_RST_REL:   prst_q  <= 1'b1;
                        RAIL_PANEL_ON:  panel_q <= 1'b1;
                        RAIL_PANEL_OFF: panel_q <= 1'b0;
                        RAIL_LOGIC_OFF: begin
                            prst_q  <= 1'b0;
                            logic_q <= 1'b0;
                        end
                        default: ;
                    endcase
                end else if (skip) begin
                    step <= step + 1'b1;
                end
                if (entry.kind == K_CLEAR) clr_q <= 1'b1;
            end

            if (state == S_WAIT && tmr_done) step <= step + 1'b1;

            if (state == S_CLEAR && clr_done) begin
                clr_q <= 1'b0;
                step  <= step + 1'b1;
            end

            if (state == S_SEND) begin
                if (bp_nack) begin
                    panel_q <= 1'b0;
                    prst_q  <= 1'b0;
                    logic_q <= 1'b0;
                    fault_q <= 1'b1;
                end else if (bp_done) begin
                    step <= step + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            S_OFF:   stat = STAT_OFF;
            S_ON:    stat = STAT_ON;
            S_SLEEP: stat = STAT_SLEEP;
            default: stat = STAT_BUSY;
        endcase
        status      = stat;
        busy        = (stat == STAT_BUSY);
        logic_en    = logic_q;
        panel_en    = panel_q;
        panel_rst_n = prst_q;
        fault       = fault_q;
        clr_req     = clr_q;
    end

    assert_panel_needs_logic_R13: assert property (@(posedge clk) disable iff (!rst_n)
        panel_en |-> logic_en && panel_rst_n);

    assert_cmd_needs_logic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> logic_en && panel_rst_n);

    assert_logic_after_panel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(logic_en) |-> !$past(panel_en) || fault);

    assert_on_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status == STAT_ON |-> panel_en && logic_en && panel_rst_n);

    assert_sleep_rails_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status == STAT_SLEEP |-> logic_en && !panel_en && panel_rst_n);

    assert_clear_before_panel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |-> !panel_en);

    assert_abort_rails_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> !logic_en && !panel_en && !panel_rst_n && status == STAT_OFF);

endmodule

// File: tb/oled_pwr_seq_bench.sv
module oled_pwr_seq_bench;

    // delay targets from the requirements: SHORT = ceil(1e6*3/1e6) = 3, LONG = 1000*2
    localparam int unsigned CLK_HZ    = 1_000_000;
    localparam int unsigned RESET_US  = 3;
    localparam int unsigned RAIL_MS   = 2;
    localparam longint      SHORT_CYC = 3;
    localparam longint      LONG_CYC  = 2000;

    logic       clk, rst_n, pump_mode;
    logic       up_req, down_req, sleep_req, wake_req;
    logic       cmd_req, cmd_ack, cmd_nack;
    logic [7:0] cmd_byte;
    logic       clr_req, clr_done;
    logic       logic_en, panel_en, panel_rst_n, busy, fault;
    logic [1:0] status;

    oled_pwr_seq #(
        .CLK_HZ   (CLK_HZ),
        .RESET_US (RESET_US),
        .RAIL_MS  (RAIL_MS)
    ) u_oled_pwr_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pump_mode   (pump_mode),
        .up_req      (up_req),
        .down_req    (down_req),
        .sleep_req   (sleep_req),
        .wake_req    (wake_req),
        .cmd_req     (cmd_req),
        .cmd_byte    (cmd_byte),
        .cmd_ack     (cmd_ack),
        .cmd_nack    (cmd_nack),
        .clr_req     (clr_req),
        .clr_done    (clr_done),
        .logic_en    (logic_en),
        .panel_en    (panel_en),
        .panel_rst_n (panel_rst_n),
        .busy        (busy),
        .status      (status),
        .fault       (fault)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    bit         summary_done = 0;
    longint     cyc = 0;
    logic [7:0] blog [0:63];
    longint     btime [0:63];
    int         bcount = 0;
    int         nack_at = -1;
    longint     t_logic_rise, t_logic_fall, t_rst_rise, t_panel_rise, t_panel_fall;
    longint     t_clear_done;
    int         clear_bcount;
    logic       clear_panel;
    int         r13_viol = 0;

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    // bus master model: logs bytes, acknowledges after two cycles (R11 checked here)
    initial begin
        cmd_ack  = 1'b0;
        cmd_nack = 1'b0;
        forever begin
            @(negedge clk);
            if (cmd_req) begin
                automatic logic [7:0] b = cmd_byte;
                automatic bit held = 1;
                if (bcount < 64) begin
                    blog[bcount]  = cmd_byte;
                    btime[bcount] = cyc;
                end
                bcount++;
                repeat (2) begin
                    @(negedge clk);
                    if (!cmd_req || cmd_byte != b) held = 0;
                end
                if (nack_at == bcount - 1) cmd_nack = 1'b1;
                else                      cmd_ack  = 1'b1;
                @(negedge clk);
                cmd_ack  = 1'b0;
                cmd_nack = 1'b0;
                chk(held && !cmd_req, "R11", "request held then dropped",
                    longint'(cmd_req), 0);
            end
        end
    end

    // clear engine model
    initial begin
        clr_done = 1'b0;
        forever begin
            @(negedge clk);
            if (clr_req) begin
                clear_bcount = bcount;
                clear_panel  = panel_en;
                repeat (3) @(negedge clk);
                clr_done     = 1'b1;
                t_clear_done = cyc;
                @(negedge clk);
                clr_done = 1'b0;
            end
        end
    end

    // rail edge monitor
    initial begin
        automatic logic p_l = 0, p_r = 0, p_p = 0;
        forever begin
            @(negedge clk);
            if (logic_en && !p_l)    t_logic_rise = cyc;
            if (!logic_en && p_l)    t_logic_fall = cyc;
            if (panel_rst_n && !p_r) t_rst_rise   = cyc;
            if (panel_en && !p_p)    t_panel_rise = cyc;
            if (!panel_en && p_p)    t_panel_fall = cyc;
            if (panel_en && !(logic_en && panel_rst_n)) r13_viol++;
            p_l = logic_en;
            p_r = panel_rst_n;
            p_p = panel_en;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "ALL", "watchdog expired", cyc, 0);
        summary();
        $finish;
    end

    function automatic logic [7:0] exp_up(int i, bit pump);
        case (i)
            0:  return 8'hAE;  1:  return 8'hD5;  2:  return 8'h80;
            3:  return 8'hA8;  4:  return 8'h0F;  5:  return 8'hD3;
            6:  return 8'h00;  7:  return 8'h40;  8:  return 8'h8D;
            9:  return pump ? 8'h14 : 8'h10;
            10: return 8'hA1;  11: return 8'hC8;  12: return 8'hDA;
            13: return 8'h02;  14: return 8'hDB;  15: return 8'h20;
            16: return 8'hD9;  17: return 8'hF1;  18: return 8'h81;
            19: return 8'hAF;  20: return 8'hA4;  21: return 8'hA6;
            22: return 8'hAF;
            default: return 8'h00;
        endcase
    endfunction

    task automatic clear_log();
        bcount       = 0;
        t_logic_rise = -1;
        t_logic_fall = -1;
        t_rst_rise   = -1;
        t_panel_rise = -1;
        t_panel_fall = -1;
        t_clear_done = -1;
        clear_bcount = -1;
    endtask

    task automatic wait_status(input logic [1:0] s, input int max);
        for (int k = 0; k < max; k++) begin
            if (status == s) break;
            @(negedge clk);
        end
    endtask

    task automatic chk_bytes(input string req, input logic [7:0] e0, input logic [7:0] e1,
                             input logic [7:0] e2, input int n);
        chk(bcount == n, req, "byte count", bcount, n);
        if (n > 0 && bcount > 0) chk(blog[0] == e0, req, "byte 0", blog[0], e0);
        if (n > 1 && bcount > 1) chk(blog[1] == e1, req, "byte 1", blog[1], e1);
        if (n > 2 && bcount > 2) chk(blog[2] == e2, req, "byte 2", blog[2], e2);
    endtask

    task automatic t_reset();
        chk(!logic_en && !panel_en && !panel_rst_n, "R1", "rails after reset",
            {logic_en, panel_en, panel_rst_n}, 0);
        chk(status == 2'd0 && !busy, "R1", "status after reset", status, 0);
        chk(!cmd_req && !clr_req && !fault, "R1", "req/fault after reset",
            {cmd_req, clr_req, fault}, 0);
    endtask

    task automatic t_idle_off();
        clear_log();
        @(negedge clk);
        sleep_req = 1; wake_req = 1; down_req = 1;
        @(negedge clk);
        sleep_req = 0; wake_req = 0; down_req = 0;
        repeat (20) @(negedge clk);
        chk(status == 2'd0, "R9", "off ignores other requests", status, 0);
        chk(bcount == 0 && !logic_en, "R9", "no bytes or rails from off", bcount, 0);
    endtask

    task automatic t_powerup(input bit pump);
        clear_log();
        pump_mode = pump;
        up_req = 1;
        @(negedge clk);
        up_req = 0;
        @(negedge clk);
        pump_mode = !pump;   // later changes must not matter
        chk(busy && status == 2'd1, "R12", "sequencing code", status, 1);
        chk(!fault, "R10", "fault cleared by power-up", fault, 0);
        repeat (20) @(negedge clk);
        sleep_req = 1; down_req = 1;
        @(negedge clk);
        sleep_req = 0; down_req = 0;
        wait_status(2'd2, 20000);
        chk(status == 2'd2 && !busy, "R5", "reaches on", status, 2);
        chk(bcount == 23, "R3", "power-up byte count", bcount, 23);
        for (int i = 0; i < 23; i++) begin
            if (i < bcount) chk(blog[i] == exp_up(i, pump), "R3", "power-up byte",
                                blog[i], exp_up(i, pump));
        end
        chk(t_rst_rise - t_logic_rise >= SHORT_CYC, "R2", "reset hold after logic on",
            t_rst_rise - t_logic_rise, SHORT_CYC);
        chk(btime[0] - t_rst_rise >= SHORT_CYC, "R2", "first byte after reset release",
            btime[0] - t_rst_rise, SHORT_CYC);
        chk(clear_bcount == 22, "R4", "clear after config bytes", clear_bcount, 22);
        chk(clear_panel == 1'b0, "R4", "panel off at clear", clear_panel, 0);
        chk(t_panel_rise > t_clear_done, "R4", "panel after clear done",
            t_panel_rise, t_clear_done + 1);
        chk(btime[22] - t_panel_rise >= LONG_CYC, "R5", "display-on after rail wait",
            btime[22] - t_panel_rise, LONG_CYC);
        chk(panel_en && logic_en && panel_rst_n, "R5", "rails when on",
            {logic_en, panel_en, panel_rst_n}, 7);
    endtask

    task automatic t_ignore_on();
        clear_log();
        up_req = 1; wake_req = 1;
        @(negedge clk);
        up_req = 0; wake_req = 0;
        repeat (30) @(negedge clk);
        chk(status == 2'd2 && panel_en, "R9", "on ignores up/wake", status, 2);
        chk(bcount == 0, "R9", "no bytes from ignored request", bcount, 0);
    endtask

    task automatic t_sleep(input bit pump);
        clear_log();
        sleep_req = 1;
        @(negedge clk);
        sleep_req = 0;
        repeat (2) @(negedge clk);
        wait_status(2'd3, 2000);
        chk(status == 2'd3, "R7", "reaches sleep", status, 3);
        chk_bytes("R7", 8'hAE, 8'h8D, 8'h10, pump ? 3 : 1);
        chk(!panel_en && logic_en && panel_rst_n, "R7", "sleep rails",
            {logic_en, panel_en, panel_rst_n}, 5);
    endtask

    task automatic t_wake(input bit pump);
        int n;
        n = pump ? 3 : 1;
        clear_log();
        wake_req = 1;
        @(negedge clk);
        wake_req = 0;
        repeat (2) @(negedge clk);
        wait_status(2'd2, 20000);
        chk(status == 2'd2 && panel_en, "R8", "wake reaches on", status, 2);
        if (pump) chk_bytes("R8", 8'h8D, 8'h14, 8'hAF, 3);
        else      chk_bytes("R8", 8'hAF, 8'h00, 8'h00, 1);
        if (bcount == n)
            chk(btime[n-1] - t_panel_rise >= LONG_CYC, "R8", "display-on after rail wait",
                btime[n-1] - t_panel_rise, LONG_CYC);
    endtask

    task automatic t_powerdown(input bit pump, input bit from_sleep);
        int n;
        n = pump ? 3 : 1;
        clear_log();
        down_req = 1;
        @(negedge clk);
        down_req = 0;
        repeat (2) @(negedge clk);
        wait_status(2'd0, 20000);
        chk(status == 2'd0, "R6", "reaches off", status, 0);
        chk_bytes("R6", 8'hAE, 8'h8D, 8'h10, n);
        chk(!logic_en && !panel_en && !panel_rst_n, "R6", "rails off",
            {logic_en, panel_en, panel_rst_n}, 0);
        if (bcount == n)
            chk(t_logic_fall - btime[n-1] >= LONG_CYC, "R6", "logic off after wait",
                t_logic_fall - btime[n-1], LONG_CYC);
        if (!from_sleep)
            chk(t_logic_fall - t_panel_fall >= LONG_CYC, "R6", "panel before logic",
                t_logic_fall - t_panel_fall, LONG_CYC);
    endtask

    task automatic t_nack();
        clear_log();
        nack_at = 5;
        pump_mode = 0;
        up_req = 1;
        @(negedge clk);
        up_req = 0;
        repeat (3) @(negedge clk);
        wait_status(2'd0, 5000);
        nack_at = -1;
        chk(status == 2'd0 && fault, "R10", "abort to off with fault", fault, 1);
        chk(!logic_en && !panel_en && !panel_rst_n, "R10", "abort rails",
            {logic_en, panel_en, panel_rst_n}, 0);
        chk(bcount == 6, "R10", "bytes before abort", bcount, 6);
        repeat (10) @(negedge clk);
        chk(fault, "R10", "fault latched", fault, 1);
    endtask

    initial begin
        rst_n = 0; pump_mode = 0;
        up_req = 0; down_req = 0; sleep_req = 0; wake_req = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_idle_off();
        t_powerup(0);
        t_ignore_on();
        t_sleep(0);
        t_wake(0);
        t_powerdown(0, 0);
        t_powerup(1);
        t_sleep(1);
        t_powerdown(1, 1);
        t_nack();
        t_powerup(0);
        chk(!fault, "R10", "fault cleared after recovery", fault, 0);
        chk(r13_viol == 0, "R13", "panel enable without logic/reset", r13_viol, 0);
        summary();
        $finish;
    end

endmodule